// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the slave side of a serial flash interface. While chip select is low it takes opcode, address and data bytes from the serial data input. Input bits are captured on rising serial-clock edges, and output bits change on falling edges, which covers both clock-idle-low and clock-idle-high hosts. A read command sets a 24-bit start address and then streams bytes from a small internal memory model for as long as the host keeps clocking. Two write commands store bytes into that model. One is a plain program command. The other is a sequential program command, where only the first frame carries an address and each later frame continues at the next location.

The serial clock, chip select, data and hold inputs are sampled by the system clock. Edges of the serial clock are detected in that domain, so the system clock must run several times faster than the serial clock. A low hold input freezes the shift state and disables the output while the serial clock keeps toggling. When hold is released, the transfer continues exactly where it stopped. If chip select rises in the middle of an opcode or before the address is complete, a one-cycle abort pulse is raised and the command has no effect.

Top module: `flash_spi_front`

## Requirements
- R1: Bits are captured on the rising serial-clock edge and output bits change on the falling edge. Transfers work with the clock idling low and with the clock idling high between frames.
- R2: Opcode 0x03 followed by three address bytes, most significant first, streams memory bytes starting at that address. Each byte is sent MSB first, and the address advances by one per byte for as long as chip select stays low.
- R3: The read address wraps from 0xFFFFFF to 0x000000 during a stream. The memory model is indexed by the low address bits.
- R4: Opcode 0x02 followed by three address bytes writes each following data byte at consecutive addresses, starting at the given address.
- R5: If chip select rises while address bytes are still expected, frame_abort pulses high for one cycle and no memory location changes.
- R6: If chip select rises after 1 to 7 bits of an opcode, frame_abort pulses. A frame with no clock edges does not raise it.
- R7: The first 0xAD frame after any other opcode carries three address bytes and then data. Each later 0xAD frame carries only data, written at the next address. Any other opcode ends this mode.
- R8: While hold is low, serial-clock edges are ignored and the output enable is low. When hold is released, the bit and byte position resume unchanged.
- R9: An unknown opcode makes the block ignore all bytes until chip select rises. No write happens and the output stays disabled.
- R10: A rising chip select resets the bit counter and the command state. The output enable is low whenever chip select is high, and the next frame decodes a fresh opcode.
- R11: After reset, memory byte i holds i XOR 0xA5, the output enable is low and frame_abort is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select, frames each command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low pause of the serial transfer |
| spi_miso | output | 1 | Serial read data |
| spi_miso_oe | output | 1 | Output enable for spi_miso, low models tri-state |
| frame_abort | output | 1 | One-cycle pulse when a frame ends inside an opcode or address |

## Verification
The bench aims at the ends of frames. It checks a chip-select rise after two address bytes, after three opcode bits, and with no clocks at all. A design that wrote on a partial address, or that flagged empty frames, would change the memory or the abort count. Hold is applied in the middle of an address byte and in the middle of a data byte while the serial clock keeps toggling. A design that counted those edges would return shifted data from the wrong address. The bench also streams across the 24-bit wrap, and it checks that the sequential program mode continues across frames without an address and ends on a read.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam int ADDR_W = 24;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_SEQ  = 8'hAD;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_RD,
        ST_PGM,
        ST_IGN
    } fe_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_PROG,
        CMD_SEQ
    } fe_cmd_e;

    // events produced by the bit framer, consumed by the command FSM
    typedef struct packed {
        logic       fall;
        logic       cs_rise;
        logic       byte_done;
        logic       part_bits;
        logic [7:0] byte_val;
    } fe_evt_t;

    function automatic fe_cmd_e decode_opc(input logic [7:0] op);
        case (op)
            OPC_READ: return CMD_READ;
            OPC_PROG: return CMD_PROG;
            OPC_SEQ:  return CMD_SEQ;
            default:  return CMD_NONE;
        endcase
    endfunction

    function automatic logic [7:0] init_byte(input int idx);
        logic [7:0] low;
        low = idx[7:0];
        return low ^ 8'hA5;
    endfunction

endpackage

// File: rtl/fe_bit_framer.sv
module fe_bit_framer
    import flash_fe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    cs_n,
    input  logic    mosi,
    input  logic    hold_n,
    output fe_evt_t evt,
    output logic    cs_active,
    output logic    hold_active
);

    logic       s_sck, s_cs, s_mosi, s_hold;
    logic       sck_prev, cs_prev;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic       live, rise;

    assign live        = ~s_cs & s_hold;
    assign rise        = s_sck & ~sck_prev & live;
    assign cs_active   = ~s_cs;
    assign hold_active = s_hold;

    always_comb begin
        evt.fall      = ~s_sck & sck_prev & live;
        evt.cs_rise   = s_cs & ~cs_prev;
        evt.byte_done = rise && (bit_cnt == 3'd7);
        evt.part_bits = (bit_cnt != 3'd0);
        evt.byte_val  = {shreg[6:0], s_mosi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_sck    <= 1'b0;
            s_cs     <= 1'b1;
            s_mosi   <= 1'b0;
            s_hold   <= 1'b1;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
        end else begin
            s_sck    <= sck;
            s_cs     <= cs_n;
            s_mosi   <= mosi;
            s_hold   <= hold_n;
            sck_prev <= s_sck;
            cs_prev  <= s_cs;
            if (s_cs) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg   <= {shreg[6:0], s_mosi};
                bit_cnt <= bit_cnt + 3'd1;
            end
        end
    end

    // R8: a paused transfer keeps its bit position and partial byte
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!s_hold && !s_cs) |=> ($stable(bit_cnt) && $stable(shreg)));

    // R10: chip select high clears the bit position
    p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
        s_cs |=> (bit_cnt == 3'd0));

endmodule

// File: rtl/fe_cmd_fsm.sv
module fe_cmd_fsm
    import flash_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fe_evt_t           evt,
    input  logic              cs_active,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              load_tx,
    output logic              rd_active,
    output logic              frame_abort
);

    fe_state_e  state;
    fe_cmd_e    cmd, dec;
    logic [1:0] addr_idx;
    logic       pending;
    logic       seq_act;
    logic       abort_q;

    assign dec         = decode_opc(evt.byte_val);
    assign wr_en       = evt.byte_done && (state == ST_PGM);
    assign wr_data     = evt.byte_val;
    assign load_tx     = evt.fall && pending && (state == ST_RD);
    assign rd_active   = (state == ST_RD);
    assign frame_abort = abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OPC;
            cmd      <= CMD_NONE;
            addr_idx <= '0;
            addr     <= '0;
            pending  <= 1'b0;
            seq_act  <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            abort_q <= evt.cs_rise &&
                       ((state == ST_ADDR) || ((state == ST_OPC) && evt.part_bits));
            if (!cs_active) begin
                state    <= ST_OPC;
                addr_idx <= '0;
                pending  <= 1'b0;
            end else begin
                if (load_tx || wr_en) addr <= addr + 1'b1;
                if (load_tx) pending <= 1'b0;
                if (evt.byte_done) begin
                    case (state)
                        ST_OPC: begin
                            cmd <= dec;
                            if (dec != CMD_SEQ) seq_act <= 1'b0;
                            case (dec)
                                CMD_READ, CMD_PROG: state <= ST_ADDR;
                                CMD_SEQ:            state <= seq_act ? ST_PGM : ST_ADDR;
                                default:            state <= ST_IGN;
                            endcase
                        end
                        ST_ADDR: begin
                            addr     <= {addr[ADDR_W-9:0], evt.byte_val};
                            addr_idx <= addr_idx + 2'd1;
                            if (addr_idx == 2'd2) begin
                                if (cmd == CMD_READ) begin
                                    state   <= ST_RD;
                                    pending <= 1'b1;
                                end else begin
                                    state <= ST_PGM;
                                    if (cmd == CMD_SEQ) seq_act <= 1'b1;
                                end
                            end
                        end
                        ST_RD:   pending <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R5: abort only follows a chip-select rise
    p_abort_at_cs_r5: assert property (@(posedge clk) disable iff (rst)
        frame_abort |-> $past(evt.cs_rise));

    // R4: each write advances the address by one
    p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (addr == $past(addr) + 1'b1));

    // R10: a frame boundary returns to opcode decode
    p_opc_after_cs_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> (state == ST_OPC));

    // R9: an ignored frame stays ignored while selected
    p_ign_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGN && cs_active) |=> (state == ST_IGN));

endmodule

// File: rtl/fe_tx_shifter.sv
module fe_tx_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] rdata,
    output logic       tx_bit
);

    logic [7:0] tx_q;

    assign tx_bit = tx_q[7];

    always_ff @(posedge clk) begin
        if (rst)        tx_q <= '0;
        else if (load)  tx_q <= rdata;
        else if (shift) tx_q <= {tx_q[6:0], 1'b0};
    end

    // R2: a freshly loaded byte presents its MSB first
    p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (tx_bit == $past(rdata[7])));

endmodule

// File: rtl/fe_mem_model.sv
module fe_mem_model
    import flash_fe_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // R4: a written byte is stored at the addressed location
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/flash_spi_front.sv
module flash_spi_front
    import flash_fe_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic spi_hold_n,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic frame_abort
);

    fe_evt_t           evt;
    logic              cs_active, hold_active;
    logic [ADDR_W-1:0] addr;
    logic              wr_en, load_tx, rd_active;
    logic [7:0]        wr_data, rdata;

    fe_bit_framer u_framer (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .hold_n(spi_hold_n), .evt(evt), .cs_active(cs_active), .hold_active(hold_active)
    );

    fe_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .cs_active(cs_active), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .load_tx(load_tx), .rd_active(rd_active),
        .frame_abort(frame_abort)
    );

    fe_mem_model #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst(rst), .we(wr_en), .addr(addr[MEM_AW-1:0]),
        .wdata(wr_data), .rdata(rdata)
    );

    fe_tx_shifter u_tx (
        .clk(clk), .rst(rst), .load(load_tx), .shift(evt.fall),
        .rdata(rdata), .tx_bit(spi_miso)
    );

    assign spi_miso_oe = cs_active & hold_active & rd_active;

    // R10: deselected device never drives the output
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $past(spi_cs_n) |-> !spi_miso_oe);

    // R8: paused device never drives the output
    p_oe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!spi_hold_n) |-> !spi_miso_oe);

endmodule

// File: tb/flash_spi_front_tb_top.sv
module flash_spi_front_tb_top;

    localparam int H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_hold_n = 1'b1;
    logic spi_miso, spi_miso_oe, frame_abort;

    int checks = 0;
    int errors = 0;
    int abort_cnt = 0;
    bit done = 1'b0;
    logic [7:0] shadow [256];

    always #2 clk = ~clk;

    flash_spi_front dut_i (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .frame_abort(frame_abort)
    );

    always @(posedge clk) if (!rst && frame_abort) abort_cnt++;

    // bit 24 selects clock idle high; low 24 bits are the start address
    localparam logic [24:0] RVEC [5] = '{
        {1'b0, 24'h000000},
        {1'b1, 24'h000010},
        {1'b0, 24'h123456},
        {1'b1, 24'hFFFFFE},
        {1'b0, 24'hFFFFFD}
    };

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic fbegin(input bit m3);
        spi_sck = m3;
        clks(H);
        spi_cs_n = 1'b0;
        clks(H);
    endtask

    task automatic fend(input bit m3);
        if (!m3) spi_sck = 1'b0;
        clks(H);
        spi_cs_n = 1'b1;
        clks(2 * H);
    endtask

    task automatic do_hold();
        spi_hold_n = 1'b0;
        clks(3);
        chk(spi_miso_oe == 1'b0, "R8 oe during hold", spi_miso_oe, 0);
        for (int t = 0; t < 2; t++) begin
            spi_sck = 1'b0; clks(H);
            spi_sck = 1'b1; clks(H);
        end
        spi_hold_n = 1'b1;
        clks(3);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        input int hold_bit, input int nbits);
        rx = '0;
        for (int b = 7; b >= 8 - nbits; b--) begin
            if (b == hold_bit) do_hold();
            spi_sck  = 1'b0;
            spi_mosi = tx[b];
            clks(H);
            rx[b]    = spi_miso;
            spi_sck  = 1'b1;
            clks(H);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] d;
        xfer(tx, d, -1, 8);
    endtask

    task automatic send_addr(input logic [23:0] a, input int hold_bit);
        logic [7:0] d;
        xfer(a[23:16], d, -1, 8);
        xfer(a[15:8], d, hold_bit, 8);
        xfer(a[7:0], d, -1, 8);
    endtask

    task automatic read_chk(input bit m3, input logic [23:0] a, input int n,
                            input int hold_byte, input string req);
        logic [7:0] d;
        logic [23:0] p;
        fbegin(m3);
        send(8'h03);
        send_addr(a, -1);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d, (k == hold_byte) ? 4 : -1, 8);
            p = a + 24'(k);
            chk(d == shadow[p[7:0]], req, d, shadow[p[7:0]]);
        end
        chk(spi_miso_oe == 1'b1, {req, " oe while streaming"}, spi_miso_oe, 1);
        fend(m3);
    endtask

    task automatic prog(input logic [7:0] opc, input logic [23:0] a, input int n,
                        input logic [7:0] base);
        fbegin(1'b0);
        send(opc);
        send_addr(a, -1);
        for (int k = 0; k < n; k++) begin
            logic [23:0] p;
            send(base + 8'(k));
            p = a + 24'(k);
            shadow[p[7:0]] = base + 8'(k);
        end
        fend(1'b0);
    endtask

    initial begin
        int ab0;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'hA5;
        clks(5);
        rst = 1'b0;
        clks(3);

        // R11: reset state of the outputs
        chk(spi_miso_oe == 1'b0, "R11 oe after reset", spi_miso_oe, 0);
        chk(frame_abort == 1'b0, "R11 abort after reset", frame_abort, 0);

        // R1 R2 R3 R11: table of read streams, both clock idle levels, across the wrap
        for (int v = 0; v < 5; v++) begin
            read_chk(RVEC[v][24], RVEC[v][23:0], 4, -1,
                     (v >= 3) ? "R3 wrap read" : "R2 R1 R11 stream read");
        end

        // R4: program then read back
        prog(8'h02, 24'h000040, 3, 8'h11);
        read_chk(1'b1, 24'h000040, 3, -1, "R4 program readback");

        // R5: partial address on a program command
        ab0 = abort_cnt;
        fbegin(1'b0);
        send(8'h02);
        send(8'h00);
        send(8'h00);
        fend(1'b0);
        chk(abort_cnt == ab0 + 1, "R5 abort count", abort_cnt, ab0 + 1);
        read_chk(1'b0, 24'h000000, 2, -1, "R5 memory unchanged");

        // R6: partial opcode, then an empty frame
        ab0 = abort_cnt;
        fbegin(1'b0);
        xfer(8'h03, d, -1, 3);
        fend(1'b0);
        chk(abort_cnt == ab0 + 1, "R6 partial opcode abort", abort_cnt, ab0 + 1);
        ab0 = abort_cnt;
        fbegin(1'b0);
        fend(1'b0);
        chk(abort_cnt == ab0, "R6 empty frame no abort", abort_cnt, ab0);

        // R10: a frame cut mid-read does not disturb the next
        fbegin(1'b0);
        send(8'h03);
        send_addr(24'h000020, -1);
        xfer(8'h00, d, -1, 3);
        fend(1'b0);
        chk(spi_miso_oe == 1'b0, "R10 oe after cs high", spi_miso_oe, 0);
        read_chk(1'b0, 24'h000021, 2, -1, "R10 fresh frame after cut");

        // R7: sequential program across frames
        fbegin(1'b0);
        send(8'hAD);
        send_addr(24'h000080, -1);
        send(8'h5A);
        fend(1'b0);
        fbegin(1'b0); send(8'hAD); send(8'h6B); fend(1'b0);
        fbegin(1'b0); send(8'hAD); send(8'h7C); fend(1'b0);
        shadow[8'h80] = 8'h5A; shadow[8'h81] = 8'h6B; shadow[8'h82] = 8'h7C;
        read_chk(1'b0, 24'h000080, 3, -1, "R7 sequential readback");
        ab0 = abort_cnt;
        fbegin(1'b0); send(8'hAD); send(8'h99); fend(1'b0);
        chk(abort_cnt == ab0 + 1, "R7 mode ended by read", abort_cnt, ab0 + 1);
        read_chk(1'b0, 24'h000083, 1, -1, "R7 no write after mode end");

        // R9: unknown opcode followed by a program-like tail
        fbegin(1'b0);
        send(8'h9F);
        send(8'h03);
        send_addr(24'h000020, -1);
        send(8'hEE);
        chk(spi_miso_oe == 1'b0, "R9 oe after unknown opcode", spi_miso_oe, 0);
        fend(1'b0);
        read_chk(1'b0, 24'h000020, 1, -1, "R9 memory unchanged");

        // R8: hold inside an address byte and inside a data byte
        fbegin(1'b1);
        send(8'h03);
        send_addr(24'h000044, 3);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, d, (k == 1) ? 4 : -1, 8);
            chk(d == shadow[8'h44 + k], "R8 read across hold", d, shadow[8'h44 + k]);
        end
        fend(1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule